// File: doc/BRIEF.md
# Floating-Point Operation Queue with Load/Store Interlock

This block sits between the integer decode stage and the floating-point arithmetic units. Decode hands every floating-point operation (opcode, destination register, two source registers) to the queue in one cycle and carries on without waiting for it. The queue holds up to `DEPTH` operations. It launches them to the arithmetic units strictly in the order they arrived. An operation whose source is still being computed by an older in-flight operation is held back. The exception is the cycle in which that older operation completes: the held operation then launches at once and is marked to take that operand from the completion bypass.

Floating-point loads and stores never enter the queue. The integer load/store unit runs them, and before it touches a floating-point register it asks the queue whether that register is still in use. A load must wait while its register is the destination or a source of any queued operation. A store must wait while its register is the destination of any queued operation. Completions come back from the units in order, and each one retires the oldest in-flight entry. A completion frees its register for the interlock in the same cycle.

Occupancy is tracked by a three-state machine. From Q_EMPTY, an accepted operation takes the queue to Q_PART (the "accept" transition). From Q_PART, filling the last slot goes to Q_FULL (the "fill" transition), and retiring the last entry goes back to Q_EMPTY (the "drain" transition). From Q_FULL, any retirement goes to Q_PART (the "free" transition). Q_FULL drives the full signal, and any state other than Q_EMPTY drives the busy signal.

Top module: `fpop_queue`

## Requirements
- R1: While reset is asserted, q_busy, q_full and launch_vld are all 0.
- R2: Every accepted operation appears on the launch port exactly once, with its opcode and registers unchanged, in acceptance order. The earliest launch is in the cycle after acceptance, never the cycle of acceptance itself.
- R3: q_full is 1 from the edge that accepts the DEPTH-th unretired operation until the edge of the next retirement. An enqueue while q_full is 1 is dropped and is never launched.
- R4: launch_vld stays 0 while the oldest unlaunched operation has a source register equal to the destination of an in-flight operation that is not completing in that cycle.
- R5: When the only blocking producer is the oldest in-flight entry and cmpl is 1, the dependent operation launches in that same cycle. launch_fwd1 and launch_fwd2 are then 1 for each source (rs1 and rs2 respectively) equal to the producer's destination, meaning the operand is taken from the completion bypass. Both flags are 0 on a launch without forwarding.
- R6: cmpl retires the oldest entry only if that entry has already launched. A cmpl with an empty queue, or with the oldest entry not yet launched (including in the cycle it launches), has no effect.
- R7: With ldst_vld=1 and ldst_store=0, ldst_hold is 1 in the same cycle when ldst_reg equals rd, rs1 or rs2 of any queued entry, and 0 otherwise.
- R8: With ldst_vld=1 and ldst_store=1, ldst_hold is 1 only when ldst_reg equals rd of a queued entry. A match on a source register alone gives 0.
- R9: An entry retiring in the current cycle (cmpl=1 while it is the oldest, launched entry) no longer causes ldst_hold in that cycle.
- R10: q_busy is 1 from the edge after the first accepted operation, and returns to 0 at the edge that retires the last entry.
- R11: ldst_hold is 0 whenever ldst_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_vld | input | 1 | Decode offers an operation this cycle |
| enq_op | input | OP_W | Opcode of the offered operation |
| enq_rd | input | REG_W | Destination register |
| enq_rs1 | input | REG_W | First source register |
| enq_rs2 | input | REG_W | Second source register |
| q_full | output | 1 | No free slot; offers are dropped |
| q_busy | output | 1 | At least one entry held |
| launch_vld | output | 1 | An operation launches this cycle |
| launch_op | output | OP_W | Opcode of the launching operation |
| launch_rd | output | REG_W | Its destination register |
| launch_rs1 | output | REG_W | Its first source register |
| launch_rs2 | output | REG_W | Its second source register |
| launch_fwd1 | output | 1 | First operand from completion bypass |
| launch_fwd2 | output | 1 | Second operand from completion bypass |
| cmpl | input | 1 | Arithmetic units finished the oldest in-flight operation |
| ldst_vld | input | 1 | Load/store unit asks about a register |
| ldst_store | input | 1 | 1 for a store query, 0 for a load query |
| ldst_reg | input | REG_W | Floating-point register of the load/store |
| ldst_hold | output | 1 | The load/store must wait |

## Verification
The launch port and ldst_hold are combinational from state and from cmpl. A launch is therefore due in the first cycle after acceptance, or in the very cycle a blocking producer completes, and a hold answer is due in the cycle of the query. q_full and q_busy pass through the occupancy register, so they change only at the edge that accepts or retires. Inputs are driven just after a rising edge. Launches and hold answers are sampled at the following falling edge, inside the cycle they belong to. Flags are read after the next rising edge. A scoreboard receives each expected launch at enqueue time and matches it against every launch the monitor observes. A dropped or duplicated operation therefore shows up as a mismatch or as an unexpected launch.

// File: rtl/fpq_pkg.sv
package fpq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } qstate_e;
endpackage

// File: rtl/fpq_ring.sv
module fpq_ring
    import fpq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int OP_W  = 6,
    parameter int REG_W = 5,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enq_vld,
    input  logic [OP_W-1:0]             enq_op,
    input  logic [REG_W-1:0]            enq_rd,
    input  logic [REG_W-1:0]            enq_rs1,
    input  logic [REG_W-1:0]            enq_rs2,
    input  logic                        launch_fire,
    input  logic                        cmpl,
    output logic [DEPTH-1:0][OP_W-1:0]  ent_op,
    output logic [DEPTH-1:0][REG_W-1:0] ent_rd,
    output logic [DEPTH-1:0][REG_W-1:0] ent_rs1,
    output logic [DEPTH-1:0][REG_W-1:0] ent_rs2,
    output logic [DEPTH-1:0]            ent_vld,
    output logic [DEPTH-1:0]            ent_flt,
    output logic [PW-1:0]               head,
    output logic [PW-1:0]               lptr,
    output logic                        retire_ok,
    output logic                        q_full,
    output logic                        q_busy
);
    qstate_e                      state_q, state_d;
    logic [CW-1:0]                count_q, count_d;
    logic [PW-1:0]                head_q, tail_q, lptr_q;
    logic [DEPTH-1:0]             vld_q, flt_q;
    logic [DEPTH-1:0][OP_W-1:0]   op_q;
    logic [DEPTH-1:0][REG_W-1:0]  rd_q, rs1_q, rs2_q;
    logic                         enq_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign enq_ok    = enq_vld && (state_q != Q_FULL);
    assign retire_ok = cmpl && vld_q[head_q] && flt_q[head_q];
    assign count_d   = count_q + CW'(enq_ok) - CW'(retire_ok);

    // next-state: accept, fill, drain, free
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: if (enq_ok) state_d = Q_PART;
            Q_PART: begin
                if (count_d == CW'(DEPTH))   state_d = Q_FULL;
                else if (count_d == '0)      state_d = Q_EMPTY;
            end
            Q_FULL:  if (retire_ok) state_d = Q_PART;
            default: state_d = Q_EMPTY;
        endcase
    end

    // state register and queue control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
            count_q <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            lptr_q  <= '0;
            vld_q   <= '0;
            flt_q   <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (launch_fire) begin
                flt_q[lptr_q] <= 1'b1;
                lptr_q        <= bump(lptr_q);
            end
            if (retire_ok) begin
                vld_q[head_q] <= 1'b0;
                flt_q[head_q] <= 1'b0;
                head_q        <= bump(head_q);
            end
            if (enq_ok) begin
                vld_q[tail_q] <= 1'b1;
                flt_q[tail_q] <= 1'b0;
                tail_q        <= bump(tail_q);
            end
        end
    end

    // payload storage, no reset needed
    always_ff @(posedge clk) begin
        if (enq_ok) begin
            op_q[tail_q]  <= enq_op;
            rd_q[tail_q]  <= enq_rd;
            rs1_q[tail_q] <= enq_rs1;
            rs2_q[tail_q] <= enq_rs2;
        end
    end

    // outputs of the state machine
    always_comb begin
        q_full = (state_q == Q_FULL);
        q_busy = (state_q != Q_EMPTY);
    end

    assign ent_op  = op_q;
    assign ent_rd  = rd_q;
    assign ent_rs1 = rs1_q;
    assign ent_rs2 = rs2_q;
    assign ent_vld = vld_q;
    assign ent_flt = flt_q;
    assign head    = head_q;
    assign lptr    = lptr_q;
endmodule

// File: rtl/fpq_launch.sv
module fpq_launch #(
    parameter int DEPTH = 4,
    parameter int OP_W  = 6,
    parameter int REG_W = 5,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][OP_W-1:0]  ent_op,
    input  logic [DEPTH-1:0][REG_W-1:0] ent_rd,
    input  logic [DEPTH-1:0][REG_W-1:0] ent_rs1,
    input  logic [DEPTH-1:0][REG_W-1:0] ent_rs2,
    input  logic [DEPTH-1:0]            ent_vld,
    input  logic [DEPTH-1:0]            ent_flt,
    input  logic [PW-1:0]               head,
    input  logic [PW-1:0]               lptr,
    input  logic                        retire_ok,
    output logic                        launch_vld,
    output logic [OP_W-1:0]             launch_op,
    output logic [REG_W-1:0]            launch_rd,
    output logic [REG_W-1:0]            launch_rs1,
    output logic [REG_W-1:0]            launch_rs2,
    output logic                        launch_fwd1,
    output logic                        launch_fwd2
);
    logic pend, blk1, blk2;

    assign launch_op  = ent_op[lptr];
    assign launch_rd  = ent_rd[lptr];
    assign launch_rs1 = ent_rs1[lptr];
    assign launch_rs2 = ent_rs2[lptr];
    assign pend       = ent_vld[lptr] && !ent_flt[lptr];

    // in-order launch: every in-flight entry is older than lptr
    always_comb begin
        blk1 = 1'b0;
        blk2 = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_vld[i] && ent_flt[i] && !(retire_ok && head == PW'(i))) begin
                if (ent_rd[i] == launch_rs1) blk1 = 1'b1;
                if (ent_rd[i] == launch_rs2) blk2 = 1'b1;
            end
        end
    end

    assign launch_vld  = pend && !blk1 && !blk2;
    assign launch_fwd1 = launch_vld && retire_ok && (ent_rd[head] == launch_rs1);
    assign launch_fwd2 = launch_vld && retire_ok && (ent_rd[head] == launch_rs2);
endmodule

// File: rtl/fpq_guard.sv
module fpq_guard #(
    parameter int DEPTH = 4,
    parameter int REG_W = 5,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][REG_W-1:0] ent_rd,
    input  logic [DEPTH-1:0][REG_W-1:0] ent_rs1,
    input  logic [DEPTH-1:0][REG_W-1:0] ent_rs2,
    input  logic [DEPTH-1:0]            ent_vld,
    input  logic [PW-1:0]               head,
    input  logic                        retire_ok,
    input  logic                        ldst_vld,
    input  logic                        ldst_store,
    input  logic [REG_W-1:0]            ldst_reg,
    output logic                        ldst_hold
);
    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic live, dst_eq, src_eq;
        assign live   = ent_vld[g] && !(retire_ok && head == PW'(g));
        assign dst_eq = (ent_rd[g] == ldst_reg);
        assign src_eq = (ent_rs1[g] == ldst_reg) || (ent_rs2[g] == ldst_reg);
        assign hit[g] = live && (dst_eq || (!ldst_store && src_eq));
    end

    assign ldst_hold = ldst_vld && (|hit);
endmodule

// File: rtl/fpop_queue.sv
module fpop_queue #(
    parameter int DEPTH = 4,
    parameter int OP_W  = 6,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_vld,
    input  logic [OP_W-1:0]  enq_op,
    input  logic [REG_W-1:0] enq_rd,
    input  logic [REG_W-1:0] enq_rs1,
    input  logic [REG_W-1:0] enq_rs2,
    output logic             q_full,
    output logic             q_busy,
    output logic             launch_vld,
    output logic [OP_W-1:0]  launch_op,
    output logic [REG_W-1:0] launch_rd,
    output logic [REG_W-1:0] launch_rs1,
    output logic [REG_W-1:0] launch_rs2,
    output logic             launch_fwd1,
    output logic             launch_fwd2,
    input  logic             cmpl,
    input  logic             ldst_vld,
    input  logic             ldst_store,
    input  logic [REG_W-1:0] ldst_reg,
    output logic             ldst_hold
);
    localparam int PW = $clog2(DEPTH);

    logic [DEPTH-1:0][OP_W-1:0]  ent_op;
    logic [DEPTH-1:0][REG_W-1:0] ent_rd, ent_rs1, ent_rs2;
    logic [DEPTH-1:0]            ent_vld, ent_flt;
    logic [PW-1:0]               head, lptr;
    logic                        retire_ok;

    fpq_ring #(.DEPTH(DEPTH), .OP_W(OP_W), .REG_W(REG_W)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .enq_vld(enq_vld), .enq_op(enq_op), .enq_rd(enq_rd),
        .enq_rs1(enq_rs1), .enq_rs2(enq_rs2),
        .launch_fire(launch_vld), .cmpl(cmpl),
        .ent_op(ent_op), .ent_rd(ent_rd), .ent_rs1(ent_rs1), .ent_rs2(ent_rs2),
        .ent_vld(ent_vld), .ent_flt(ent_flt), .head(head), .lptr(lptr),
        .retire_ok(retire_ok), .q_full(q_full), .q_busy(q_busy)
    );

    fpq_launch #(.DEPTH(DEPTH), .OP_W(OP_W), .REG_W(REG_W)) u_launch (
        .ent_op(ent_op), .ent_rd(ent_rd), .ent_rs1(ent_rs1), .ent_rs2(ent_rs2),
        .ent_vld(ent_vld), .ent_flt(ent_flt), .head(head), .lptr(lptr),
        .retire_ok(retire_ok),
        .launch_vld(launch_vld), .launch_op(launch_op), .launch_rd(launch_rd),
        .launch_rs1(launch_rs1), .launch_rs2(launch_rs2),
        .launch_fwd1(launch_fwd1), .launch_fwd2(launch_fwd2)
    );

    fpq_guard #(.DEPTH(DEPTH), .REG_W(REG_W)) u_guard (
        .ent_rd(ent_rd), .ent_rs1(ent_rs1), .ent_rs2(ent_rs2),
        .ent_vld(ent_vld), .head(head), .retire_ok(retire_ok),
        .ldst_vld(ldst_vld), .ldst_store(ldst_store), .ldst_reg(ldst_reg),
        .ldst_hold(ldst_hold)
    );
endmodule

// File: rtl/fpq_chk.sv
module fpq_chk (
    input logic clk,
    input logic rst_n,
    input logic enq_vld,
    input logic cmpl,
    input logic q_full,
    input logic q_busy,
    input logic launch_vld,
    input logic launch_fwd1,
    input logic launch_fwd2,
    input logic ldst_vld,
    input logic ldst_hold
);
    // R3
    no_launch_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_busy |-> !launch_vld);
    // R3
    full_is_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> q_busy);
    // R3
    full_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !cmpl) |=> q_full);
    // R10
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_busy) |-> $past(enq_vld));
    // R5
    fwd_needs_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_fwd1 || launch_fwd2) |-> (launch_vld && cmpl));
    // R11
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ldst_vld |-> !ldst_hold);
endmodule

bind fpop_queue fpq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enq_vld(enq_vld), .cmpl(cmpl),
    .q_full(q_full), .q_busy(q_busy), .launch_vld(launch_vld),
    .launch_fwd1(launch_fwd1), .launch_fwd2(launch_fwd2),
    .ldst_vld(ldst_vld), .ldst_hold(ldst_hold)
);

// File: tb/sim_fpop_queue.sv
module sim_fpop_queue;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enq_vld = 1'b0;
    logic [5:0] enq_op = '0;
    logic [4:0] enq_rd = '0, enq_rs1 = '0, enq_rs2 = '0;
    logic       q_full, q_busy, launch_vld, launch_fwd1, launch_fwd2, ldst_hold;
    logic [5:0] launch_op;
    logic [4:0] launch_rd, launch_rs1, launch_rs2;
    logic       cmpl = 1'b0, ldst_vld = 1'b0, ldst_store = 1'b0;
    logic [4:0] ldst_reg = '0;

    typedef struct packed {
        logic [5:0] op;
        logic [4:0] rd, rs1, rs2;
        logic       f1, f2;
    } exp_t;
    exp_t sb[$];
    int n_chk = 0, n_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    fpop_queue u0 (
        .clk(clk), .rst_n(rst_n), .enq_vld(enq_vld), .enq_op(enq_op),
        .enq_rd(enq_rd), .enq_rs1(enq_rs1), .enq_rs2(enq_rs2),
        .q_full(q_full), .q_busy(q_busy), .launch_vld(launch_vld),
        .launch_op(launch_op), .launch_rd(launch_rd), .launch_rs1(launch_rs1),
        .launch_rs2(launch_rs2), .launch_fwd1(launch_fwd1), .launch_fwd2(launch_fwd2),
        .cmpl(cmpl), .ldst_vld(ldst_vld), .ldst_store(ldst_store),
        .ldst_reg(ldst_reg), .ldst_hold(ldst_hold)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // monitor: pop and compare every launch
    always @(negedge clk) begin : mon
        exp_t e;
        if (rst_n && launch_vld) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3", "unexpected launch", int'(launch_op), -1);
            end else begin
                e = sb.pop_front();
                check({launch_op, launch_rd, launch_rs1, launch_rs2} == {e.op, e.rd, e.rs1, e.rs2},
                      "R2", "launch fields",
                      int'({launch_op, launch_rd, launch_rs1, launch_rs2}),
                      int'({e.op, e.rd, e.rs1, e.rs2}));
                check({launch_fwd1, launch_fwd2} == {e.f1, e.f2}, "R5", "forward select",
                      int'({launch_fwd1, launch_fwd2}), int'({e.f1, e.f2}));
            end
        end
    end

    // driver: offer one operation, push the expectation
    task automatic enq(input logic [5:0] op, input logic [4:0] rd, input logic [4:0] a,
                       input logic [4:0] b, input bit f1, input bit f2, input bit push);
        enq_vld = 1'b1; enq_op = op; enq_rd = rd; enq_rs1 = a; enq_rs2 = b;
        if (push) sb.push_back('{op: op, rd: rd, rs1: a, rs2: b, f1: f1, f2: f2});
        @(posedge clk); #1;
        enq_vld = 1'b0;
    endtask

    task automatic cmpl_pulse();
        cmpl = 1'b1;
        @(posedge clk); #1;
        cmpl = 1'b0;
    endtask

    task automatic idle_launch(input string req);
        @(negedge clk);
        check(!launch_vld, req, "launch while blocked", int'(launch_vld), 0);
        @(posedge clk); #1;
    endtask

    task automatic hold_probe(input bit st, input logic [4:0] r, input bit v,
                              input bit c, input bit exp, input string req);
        ldst_store = st; ldst_reg = r; ldst_vld = v; cmpl = c;
        @(negedge clk);
        check(ldst_hold == exp, req, "ldst_hold", int'(ldst_hold), int'(exp));
        @(posedge clk); #1;
        ldst_vld = 1'b0; cmpl = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check(!q_busy && !q_full && !launch_vld, "R1", "reset outputs",
              int'({q_busy, q_full, launch_vld}), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R2/R10: three independent operations, no launch in the accept cycle
        check(!q_busy, "R10", "busy before enqueue", int'(q_busy), 0);
        enq_vld = 1'b1; enq_op = 6'd1; enq_rd = 5'd1; enq_rs1 = 5'd2; enq_rs2 = 5'd3;
        sb.push_back('{op: 6'd1, rd: 5'd1, rs1: 5'd2, rs2: 5'd3, f1: 1'b0, f2: 1'b0});
        @(negedge clk);
        check(!launch_vld, "R2", "launch in accept cycle", int'(launch_vld), 0);
        @(posedge clk); #1;
        enq_vld = 1'b0;
        check(q_busy, "R10", "busy after enqueue", int'(q_busy), 1);
        enq(6'd2, 5'd4, 5'd5, 5'd6, 0, 0, 1);
        enq(6'd3, 5'd8, 5'd9, 5'd10, 0, 0, 1);
        @(posedge clk); #1;
        cmpl_pulse();
        cmpl_pulse();
        check(q_busy, "R10", "busy with one left", int'(q_busy), 1);
        cmpl_pulse();
        check(!q_busy, "R10", "busy after last retire", int'(q_busy), 0);
        check(sb.size() == 0, "R2", "launches outstanding", sb.size(), 0);

        // R3: fill, drop an extra offer, free
        for (int k = 0; k < 4; k++)
            enq(6'(4 + k), 5'(11 + k), 5'd15, 5'd16, 0, 0, 1);
        check(q_full, "R3", "full after four", int'(q_full), 1);
        enq(6'd63, 5'd30, 5'd31, 5'd29, 0, 0, 0);
        check(q_full, "R3", "full after dropped offer", int'(q_full), 1);
        @(posedge clk); #1;
        cmpl_pulse();
        check(!q_full, "R3", "full after retire", int'(q_full), 0);
        cmpl_pulse();
        cmpl_pulse();
        cmpl_pulse();
        check(!q_busy, "R3", "busy after draining", int'(q_busy), 0);

        // R6: completion ignored when empty or head not yet launched
        cmpl_pulse();
        check(!q_busy, "R6", "cmpl on empty queue", int'(q_busy), 0);
        enq(6'd8, 5'd20, 5'd21, 5'd22, 0, 0, 1);
        cmpl_pulse();
        check(q_busy, "R6", "cmpl on launching head", int'(q_busy), 1);
        hold_probe(1'b0, 5'd20, 1'b1, 1'b0, 1'b1, "R6");
        cmpl_pulse();
        check(!q_busy, "R6", "retire of launched head", int'(q_busy), 0);

        // R7/R8/R9/R11: interlock queries against one in-flight entry
        enq(6'd9, 5'd7, 5'd8, 5'd9, 0, 0, 1);
        @(posedge clk); #1;
        hold_probe(1'b0, 5'd7,  1'b1, 1'b0, 1'b1, "R7");
        hold_probe(1'b0, 5'd8,  1'b1, 1'b0, 1'b1, "R7");
        hold_probe(1'b0, 5'd9,  1'b1, 1'b0, 1'b1, "R7");
        hold_probe(1'b0, 5'd10, 1'b1, 1'b0, 1'b0, "R7");
        hold_probe(1'b1, 5'd7,  1'b1, 1'b0, 1'b1, "R8");
        hold_probe(1'b1, 5'd8,  1'b1, 1'b0, 1'b0, "R8");
        hold_probe(1'b0, 5'd7,  1'b0, 1'b0, 1'b0, "R11");
        hold_probe(1'b0, 5'd7,  1'b1, 1'b1, 1'b0, "R9");
        check(!q_busy, "R9", "busy after retire", int'(q_busy), 0);

        // R4/R5: dependent on the head, forwarded on rs1
        enq(6'd10, 5'd5, 5'd1, 5'd2, 0, 0, 1);
        enq(6'd11, 5'd6, 5'd5, 5'd3, 1, 0, 1);
        idle_launch("R4");
        idle_launch("R4");
        cmpl_pulse();
        cmpl_pulse();
        check(!q_busy && sb.size() == 0, "R5", "forwarded op launched and retired",
              sb.size(), 0);

        // R4/R5: producer behind the head, forwarded on rs2
        enq(6'd12, 5'd1, 5'd3, 5'd4, 0, 0, 1);
        enq(6'd13, 5'd2, 5'd3, 5'd4, 0, 0, 1);
        enq(6'd14, 5'd9, 5'd17, 5'd2, 0, 1, 1);
        idle_launch("R4");
        cmpl = 1'b1;
        @(negedge clk);
        check(!launch_vld, "R4", "launch while younger producer in flight",
              int'(launch_vld), 0);
        @(posedge clk); #1;
        cmpl = 1'b0;
        cmpl_pulse();
        cmpl_pulse();
        check(!q_busy, "R6", "busy after final retire", int'(q_busy), 0);
        check(sb.size() == 0, "R2", "launches outstanding at end", sb.size(), 0);

        finish_up();
    end
endmodule